// File: doc/BRIEF.md
# Multi-port GPIO register bank with APB access

This block is a general-purpose I/O controller reached over an APB slave port. It has from one to four ports. Each port is from 1 to 32 pins wide and has three writable registers: an output value, a drive enable and a source select. A fourth register in each port is read-only and shows the synchronised level of that port's input pins. For each pin, the source select decides who drives it. Software drives it through the value and enable registers, or a hardware function drives it through a value input and an enable input of its own.

The port count and each port's width are elaboration parameters. Two read-only words report them, so driver code can find the layout at run time. All pins of the present ports are packed into flat buses. Port A takes the lowest bits, and each later port follows directly above the one before it. Every bus transfer completes without wait states.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every output value, drive enable and source select bit is 0. So pin_out and pin_oe are all 0, and each of these registers reads back as 0.
- R2: Port p (0 for A up to 3 for D) has its output value register at byte address 12*p, its drive enable register at 12*p+4 and its source select register at 12*p+8. A write in the access phase (psel, penable and pwrite high) takes effect at that clock edge and reads back afterwards.
- R3: Pins are packed with port A in the lowest bits of pin_in, hw_dout, hw_oe, pin_out and pin_oe, then port B, C and D in turn. With a source select bit of 0, pin_oe for that pin equals its drive enable bit: 1 drives the pin and 0 leaves it as an input.
- R4: With a source select bit of 0, pin_out follows the output value bit whatever the enable bit is. A value written before the enable therefore already appears on pin_out when pin_oe rises. A value write never changes pin_oe, and an enable write never changes pin_out.
- R5: With a source select bit of 1, pin_out and pin_oe for that pin follow hw_dout and hw_oe in the same cycle, and the software registers have no effect on the pin.
- R6: The read-only input word of port p is at byte address 0x50+4*p. It returns pin_in after two clock stages: a level present at clock edge k can be read from edge k+2 onward. Writes to this address change nothing.
- R7: The read-only word at 0x70 holds width-1 of port A in bits 4:0, port B in bits 9:5, port C in bits 14:10 and port D in bits 19:15. The fields of absent ports and all other bits are 0. Writes to it are ignored.
- R8: The read-only word at 0x74 holds the port count minus 1 in bits 3:2, with all other bits 0. Writes to it are ignored.
- R9: Register bits at or above a port's width read as 0, and writes to them are dropped.
- R10: Any address not listed above, including unaligned ones and the registers of absent ports, reads as 0, and a write to it changes no register and no pin. pslverr is always 0.
- R11: pready is 1 in every access phase, so each transfer takes exactly one setup and one access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| pin_in | input | NPIN | Input pin levels, all ports packed |
| hw_dout | input | NPIN | Hardware-source output values |
| hw_oe | input | NPIN | Hardware-source drive enables |
| pin_out | output | NPIN | Output value to each pad |
| pin_oe | output | NPIN | Drive enable to each pad |

## Verification
Two things can happen in the same cycle. A bus write can change a source select or drive enable register at a clock edge while the hardware source inputs or the input pins change near that same edge. The bench provokes this by changing hw_dout at the access-phase edge of a source select write, and by changing pin_in at the setup cycle of an input read. Every cycle, a behavioural model that knows only the register semantics and the two-stage input delay is compared with pin_out, pin_oe and the read data. This shows whether the old or the new source and pin level won at the edge.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

   localparam int unsigned LANE_W      = 32;
   localparam int unsigned MAX_PORTS   = 4;
   localparam int unsigned PORT_STRIDE = 12;
   localparam int unsigned OFS_DATA    = 0;
   localparam int unsigned OFS_DIR     = 4;
   localparam int unsigned OFS_SRC     = 8;
   localparam int unsigned EXT_BASE    = 'h50;
   localparam int unsigned EXT_STRIDE  = 4;
   localparam int unsigned CFG_WIDTHS  = 'h70;
   localparam int unsigned CFG_COUNT   = 'h74;
   localparam int unsigned WFIELD_W    = 5;
   localparam int unsigned CNT_LSB     = 2;

   // width of port idx, 0 when the port is absent
   function automatic int unsigned port_width(input int unsigned idx,
                                              input int unsigned ports,
                                              input int unsigned wa,
                                              input int unsigned wb,
                                              input int unsigned wc,
                                              input int unsigned wd);
      int unsigned w;
      case (idx)
         0:       w = wa;
         1:       w = wb;
         2:       w = wc;
         default: w = wd;
      endcase
      return (idx < ports) ? w : 0;
   endfunction

   // lowest packed pin index of port idx (or total pin count for idx = 4)
   function automatic int unsigned lane_base(input int unsigned idx,
                                             input int unsigned ports,
                                             input int unsigned wa,
                                             input int unsigned wb,
                                             input int unsigned wc,
                                             input int unsigned wd);
      int unsigned sum = 0;
      for (int unsigned i = 0; i < MAX_PORTS; i++)
         if (i < idx) sum += port_width(i, ports, wa, wb, wc, wd);
      return sum;
   endfunction

   // self-describing width word: width-1 per present port
   function automatic logic [31:0] width_word(input int unsigned ports,
                                              input int unsigned wa,
                                              input int unsigned wb,
                                              input int unsigned wc,
                                              input int unsigned wd);
      logic [31:0] word = '0;
      for (int unsigned i = 0; i < MAX_PORTS; i++)
         if (i < ports)
            word[i*WFIELD_W +: WFIELD_W] =
               WFIELD_W'(port_width(i, ports, wa, wb, wc, wd) - 1);
      return word;
   endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
   parameter int unsigned W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end

endmodule

// File: rtl/gpb_port.sv
module gpb_port
   import gpb_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned IDX    = 0,
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   input  logic [W-1:0]      pin_in,
   input  logic [W-1:0]      hw_dout,
   input  logic [W-1:0]      hw_oe,
   output logic [W-1:0]      pin_out,
   output logic [W-1:0]      pin_oe,
   output logic [W-1:0]      rd_data
);

   localparam int unsigned     BASE   = IDX * PORT_STRIDE;
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE + OFS_DATA);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(BASE + OFS_DIR);
   localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(BASE + OFS_SRC);
   localparam logic [ADDR_W-1:0] A_EXT  = ADDR_W'(EXT_BASE + IDX * EXT_STRIDE);

   logic [W-1:0] data_q;
   logic [W-1:0] dir_q;
   logic [W-1:0] src_q;
   logic [W-1:0] pin_s;

   // software registers, written in the access phase
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         src_q  <= '0;
      end else if (wr_en) begin
         case (addr)
            A_DATA:  data_q <= wdata;
            A_DIR:   dir_q  <= wdata;
            A_SRC:   src_q  <= wdata;
            default: ;
         endcase
      end
   end

   gpb_sync #(.W(W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   // per-pin source select; value and enable are independent registers,
   // so a value write settles before the enable that follows it
   for (genvar b = 0; b < W; b++) begin : g_bit
      assign pin_out[b] = src_q[b] ? hw_dout[b] : data_q[b];
      assign pin_oe[b]  = src_q[b] ? hw_oe[b]   : dir_q[b];
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (addr)
            A_DATA:  rd_data = data_q;
            A_DIR:   rd_data = dir_q;
            A_SRC:   rd_data = src_q;
            A_EXT:   rd_data = pin_s;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/gpb_cfg.sv
module gpb_cfg
   import gpb_pkg::*;
#(
   parameter int unsigned PORTS   = 4,
   parameter int unsigned WIDTH_A = 32,
   parameter int unsigned WIDTH_B = 32,
   parameter int unsigned WIDTH_C = 32,
   parameter int unsigned WIDTH_D = 32,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   output logic [31:0]       rd_data
);

   localparam logic [31:0] WORD_W =
      width_word(PORTS, WIDTH_A, WIDTH_B, WIDTH_C, WIDTH_D);
   localparam logic [31:0] WORD_N = 32'(PORTS - 1) << CNT_LSB;
   localparam logic [ADDR_W-1:0] A_WID = ADDR_W'(CFG_WIDTHS);
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CFG_COUNT);

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         if (addr == A_WID)      rd_data = WORD_W;
         else if (addr == A_CNT) rd_data = WORD_N;
      end
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpb_pkg::*;
#(
   parameter int unsigned PORTS   = 4,
   parameter int unsigned WIDTH_A = 32,
   parameter int unsigned WIDTH_B = 12,
   parameter int unsigned WIDTH_C = 8,
   parameter int unsigned WIDTH_D = 5,
   parameter int unsigned ADDR_W  = 8,
   localparam int unsigned NPIN =
      lane_base(MAX_PORTS, PORTS, WIDTH_A, WIDTH_B, WIDTH_C, WIDTH_D)
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [NPIN-1:0]   pin_in,
   input  logic [NPIN-1:0]   hw_dout,
   input  logic [NPIN-1:0]   hw_oe,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe
);

   // elaboration-time parameter checks
   if (PORTS < 1 || PORTS > MAX_PORTS) begin : g_bad_ports
      $error("gpio_bank: PORTS out of range");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_bank: ADDR_W too narrow for the register map");
   end

   logic        wr_en;
   logic        rd_en;
   logic [31:0] lane_rd [MAX_PORTS];
   logic [31:0] cfg_rd;

   assign wr_en = psel & penable & pwrite;
   assign rd_en = psel & ~pwrite;

   for (genvar p = 0; p < MAX_PORTS; p++) begin : g_lane
      localparam int unsigned PW =
         port_width(p, PORTS, WIDTH_A, WIDTH_B, WIDTH_C, WIDTH_D);
      localparam int unsigned LO =
         lane_base(p, PORTS, WIDTH_A, WIDTH_B, WIDTH_C, WIDTH_D);
      if (p < PORTS) begin : g_on
         if (PW < 1 || PW > LANE_W) begin : g_bad_width
            $error("gpio_bank: port width out of range");
         end
         logic [PW-1:0] rd_w;
         gpb_port #(.W(PW), .IDX(p), .ADDR_W(ADDR_W)) u_port (
            .clk     (pclk),
            .rst_n   (presetn),
            .wr_en   (wr_en),
            .rd_en   (rd_en),
            .addr    (paddr),
            .wdata   (pwdata[PW-1:0]),
            .pin_in  (pin_in[LO +: PW]),
            .hw_dout (hw_dout[LO +: PW]),
            .hw_oe   (hw_oe[LO +: PW]),
            .pin_out (pin_out[LO +: PW]),
            .pin_oe  (pin_oe[LO +: PW]),
            .rd_data (rd_w)
         );
         assign lane_rd[p] = 32'(rd_w);
      end else begin : g_off
         assign lane_rd[p] = '0;
      end
   end

   gpb_cfg #(
      .PORTS   (PORTS),
      .WIDTH_A (WIDTH_A),
      .WIDTH_B (WIDTH_B),
      .WIDTH_C (WIDTH_C),
      .WIDTH_D (WIDTH_D),
      .ADDR_W  (ADDR_W)
   ) u_cfg (
      .rd_en   (rd_en),
      .addr    (paddr),
      .rd_data (cfg_rd)
   );

   // at most one source decodes a given address, so an OR merges them
   always_comb begin
      prdata = cfg_rd;
      for (int unsigned p = 0; p < MAX_PORTS; p++) prdata |= lane_rd[p];
   end

   assign pready  = 1'b1;
   assign pslverr = 1'b0;

endmodule

// File: rtl/gpb_chk.sv
module gpb_chk #(
   parameter int unsigned PORTS   = 4,
   parameter int unsigned WIDTH_A = 32,
   parameter int unsigned WIDTH_B = 12,
   parameter int unsigned WIDTH_C = 8,
   parameter int unsigned WIDTH_D = 5,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned NPIN    = WIDTH_A + WIDTH_B + WIDTH_C + WIDTH_D
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       prdata,
   input logic              pready,
   input logic              pslverr,
   input logic [NPIN-1:0]   pin_in,
   input logic [NPIN-1:0]   hw_dout,
   input logic [NPIN-1:0]   hw_oe,
   input logic [NPIN-1:0]   pin_out,
   input logic [NPIN-1:0]   pin_oe
);

   logic             rd_acc;
   logic             wr_acc;
   logic [1:0]       since_rst;
   logic [WIDTH_A-1:0] pin_a;

   assign rd_acc = psel && penable && !pwrite;
   assign wr_acc = psel && penable && pwrite;
   assign pin_a  = pin_in[WIDTH_A-1:0];

   always_ff @(posedge pclk or negedge presetn) begin
      if (!presetn)            since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_zero_wait_R11: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && penable) |-> (pready && !pslverr));

   assert_unmapped_zero_R10: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_acc && paddr == ADDR_W'('h60)) |-> (prdata == 32'd0));

   assert_count_word_R8: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_acc && paddr == ADDR_W'('h74)) |-> (prdata == (32'(PORTS - 1) << 2)));

   assert_upper_zero_R9: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_acc && paddr == ADDR_W'(12)) |-> ((64'(prdata) >> WIDTH_B) == 64'd0));

   assert_value_keeps_oe_R4: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_acc && paddr == ADDR_W'(0)) |=> ($stable(hw_oe) -> $stable(pin_oe)));

   assert_enable_keeps_out_R4: assert property (@(posedge pclk) disable iff (!presetn)
      (wr_acc && paddr == ADDR_W'(4)) |=> ($stable(hw_dout) -> $stable(pin_out)));

   assert_idle_hold_R5: assert property (@(posedge pclk) disable iff (!presetn)
      !wr_acc |=> (($stable(hw_dout) && $stable(hw_oe)) ->
                   ($stable(pin_out) && $stable(pin_oe))));

   assert_input_delay_R6: assert property (@(posedge pclk) disable iff (!presetn)
      (since_rst >= 2'd2 && rd_acc && paddr == ADDR_W'('h50))
         |-> (prdata[WIDTH_A-1:0] == $past(pin_a, 2)));

endmodule

bind gpio_bank gpb_chk #(
   .PORTS   (PORTS),
   .WIDTH_A (WIDTH_A),
   .WIDTH_B (WIDTH_B),
   .WIDTH_C (WIDTH_C),
   .WIDTH_D (WIDTH_D),
   .ADDR_W  (ADDR_W),
   .NPIN    (NPIN)
) u_chk (
   .pclk    (pclk),
   .presetn (presetn),
   .psel    (psel),
   .penable (penable),
   .pwrite  (pwrite),
   .paddr   (paddr),
   .prdata  (prdata),
   .pready  (pready),
   .pslverr (pslverr),
   .pin_in  (pin_in),
   .hw_dout (hw_dout),
   .hw_oe   (hw_oe),
   .pin_out (pin_out),
   .pin_oe  (pin_oe)
);

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;

   localparam int unsigned PORTS = 4;
   localparam int unsigned WA = 32, WB = 12, WC = 8, WD = 5;
   localparam int unsigned NPIN = WA + WB + WC + WD;
   localparam int unsigned PW [4] = '{WA, WB, WC, WD};
   localparam int unsigned LO [4] = '{0, WA, WA + WB, WA + WB + WC};

   logic            pclk = 1'b0;
   logic            presetn = 1'b0;
   logic            psel = 1'b0;
   logic            penable = 1'b0;
   logic            pwrite = 1'b0;
   logic [7:0]      paddr = '0;
   logic [31:0]     pwdata = '0;
   logic [31:0]     prdata;
   logic            pready;
   logic            pslverr;
   logic [NPIN-1:0] pin_in = '0;
   logic [NPIN-1:0] hw_dout = '0;
   logic [NPIN-1:0] hw_oe = '0;
   logic [NPIN-1:0] pin_out;
   logic [NPIN-1:0] pin_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 pclk = ~pclk;

   gpio_bank #(
      .PORTS(PORTS), .WIDTH_A(WA), .WIDTH_B(WB), .WIDTH_C(WC), .WIDTH_D(WD),
      .ADDR_W(8)
   ) dut_i (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .pin_in(pin_in), .hw_dout(hw_dout),
      .hw_oe(hw_oe), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // ---------------- behavioural reference model ----------------
   logic [31:0]     m_val [4];
   logic [31:0]     m_en  [4];
   logic [31:0]     m_src [4];
   logic [NPIN-1:0] m_s1, m_s2;

   function automatic logic [31:0] mask_of(int p);
      return (PW[p] == 32) ? 32'hFFFF_FFFF : ((32'h1 << PW[p]) - 32'h1);
   endfunction

   function automatic logic [NPIN-1:0] exp_pins(bit want_oe);
      logic [NPIN-1:0] v = '0;
      for (int p = 0; p < PORTS; p++)
         for (int b = 0; b < PW[p]; b++) begin
            if (m_src[p][b]) v[LO[p]+b] = want_oe ? hw_oe[LO[p]+b] : hw_dout[LO[p]+b];
            else             v[LO[p]+b] = want_oe ? m_en[p][b]     : m_val[p][b];
         end
      return v;
   endfunction

   function automatic logic [31:0] mread(logic [7:0] a);
      logic [31:0] w = '0;
      for (int p = 0; p < PORTS; p++) begin
         if (a == 8'(12*p))     return m_val[p];
         if (a == 8'(12*p + 4)) return m_en[p];
         if (a == 8'(12*p + 8)) return m_src[p];
         if (a == 8'('h50 + 4*p)) return 32'(m_s2 >> LO[p]) & mask_of(p);
      end
      if (a == 8'h70) begin
         for (int p = 0; p < PORTS; p++) w[p*5 +: 5] = 5'(PW[p] - 1);
         return w;
      end
      if (a == 8'h74) return 32'(PORTS - 1) << 2;
      return 32'h0;
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // model update at each edge, pin comparison 2 ns later
   always @(posedge pclk) begin
      if (!presetn) begin
         for (int p = 0; p < 4; p++) begin
            m_val[p] = '0; m_en[p] = '0; m_src[p] = '0;
         end
         m_s1 = '0; m_s2 = '0;
      end else begin
         m_s2 = m_s1;
         m_s1 = pin_in;
         if (psel && penable && pwrite)
            for (int p = 0; p < PORTS; p++) begin
               if (paddr == 8'(12*p))     m_val[p] = pwdata & mask_of(p);
               if (paddr == 8'(12*p + 4)) m_en[p]  = pwdata & mask_of(p);
               if (paddr == 8'(12*p + 8)) m_src[p] = pwdata & mask_of(p);
            end
      end
      #2;
      chk("R4/R5 pin_out per cycle", 64'(pin_out), 64'(exp_pins(1'b0)));
      chk("R3/R5 pin_oe per cycle",  64'(pin_oe),  64'(exp_pins(1'b1)));
   end

   // ---------------- bus tasks ----------------
   task automatic apb_wr(logic [7:0] a, logic [31:0] d);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      #1 chk("R11 pready on write", 64'(pready), 64'd1);
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(logic [7:0] a, string tag);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      #1;
      chk(tag, 64'(prdata), 64'(mread(a)));
      chk("R10 pslverr low", 64'(pslverr), 64'd0);
      chk("R11 pready on read", 64'(pready), 64'd1);
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   // read with the pins changed in the same cycle as the setup phase
   task automatic apb_rd_pinchg(logic [7:0] a, logic [NPIN-1:0] np, string tag);
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      pin_in = np;
      @(negedge pclk);
      penable = 1'b1;
      #1 chk(tag, 64'(prdata), 64'(mread(a)));
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic rd_all_regs(string tag);
      for (int p = 0; p < PORTS; p++) begin
         apb_rd(8'(12*p), tag);
         apb_rd(8'(12*p + 4), tag);
         apb_rd(8'(12*p + 8), tag);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge pclk);
      // R1: reset state at the pins and in the registers
      chk("R1 pin_out reset", 64'(pin_out), 64'd0);
      chk("R1 pin_oe reset",  64'(pin_oe),  64'd0);
      presetn = 1'b1;
      rd_all_regs("R1 register reset value");

      // R2 and R9: write/readback of every register, full-ones pattern
      for (int p = 0; p < PORTS; p++) begin
         apb_wr(8'(12*p),     32'hFFFF_FFFF);
         apb_wr(8'(12*p + 4), 32'hA5A5_5A5A ^ 32'(p));
         apb_wr(8'(12*p + 8), 32'h0);
      end
      rd_all_regs("R2 R9 readback masked to width");
      apb_rd(8'd12, "R9 port B value upper bits zero");

      // clear everything again
      for (int p = 0; p < PORTS; p++) begin
         apb_wr(8'(12*p), 32'h0);
         apb_wr(8'(12*p + 4), 32'h0);
      end

      // R4: value first, then enable: no glitch, value present at enable rise
      apb_wr(8'h00, 32'h0000_00F0);
      chk("R4 value visible before enable", 64'(pin_out[31:0]), 64'h0000_00F0);
      chk("R3 pin still input",             64'(pin_oe[31:0]),  64'h0);
      apb_wr(8'h04, 32'h0000_00FF);
      chk("R3 enable drives pins",          64'(pin_oe[31:0]),  64'h0000_00FF);
      chk("R4 value held across enable",    64'(pin_out[31:0]), 64'h0000_00F0);

      // R5: hardware source on port C
      @(negedge pclk);
      hw_dout[LO[2] +: 8] = 8'h3C;
      hw_oe[LO[2] +: 8]   = 8'h0F;
      apb_wr(8'd32, 32'h0000_00FF);
      chk("R5 hw value on port C", 64'(pin_out[LO[2] +: 8]), 64'h3C);
      chk("R5 hw enable on port C", 64'(pin_oe[LO[2] +: 8]), 64'h0F);
      apb_wr(8'd24, 32'h0000_0055);   // software value hidden by source select
      chk("R5 software value has no effect", 64'(pin_out[LO[2] +: 8]), 64'h3C);
      @(negedge pclk);
      hw_dout[LO[2] +: 8] = 8'hC3;
      @(negedge pclk);
      chk("R5 hw value follows", 64'(pin_out[LO[2] +: 8]), 64'hC3);

      // same-cycle: source select write on port D while hw_dout changes at that edge
      @(negedge pclk);
      psel = 1'b1; pwrite = 1'b1; paddr = 8'd44; pwdata = 32'h0000_0015; penable = 1'b0;
      @(negedge pclk);
      penable = 1'b1;
      hw_dout[LO[3] +: 5] = 5'h1F;
      hw_oe[LO[3] +: 5]   = 5'h0A;
      @(negedge pclk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      chk("R5 mixed-source port D value", 64'(pin_out[LO[3] +: 5]), 64'h15);
      chk("R5 mixed-source port D enable", 64'(pin_oe[LO[3] +: 5]), 64'h00);

      // R6: input synchroniser latency and read-only input words
      apb_rd_pinchg(8'h50, {NPIN{1'b0}} | 64'hDEAD_BEEF, "R6 old level one edge after change");
      apb_rd(8'h50, "R6 new level after two edges");
      @(negedge pclk);
      pin_in = 57'h1AB_CDEF_0123_4567;
      repeat (3) @(negedge pclk);
      for (int p = 0; p < PORTS; p++) apb_rd(8'('h50 + 4*p), "R6 input word per port");
      apb_wr(8'h50, 32'h0);
      apb_rd(8'h50, "R6 write to input word ignored");
      rd_all_regs("R6 write to input word changes no register");

      // R7, R8: configuration words, writes ignored
      apb_rd(8'h70, "R7 width word");
      apb_rd(8'h74, "R8 count word");
      apb_wr(8'h70, 32'h0);
      apb_wr(8'h74, 32'hFFFF_FFFF);
      apb_rd(8'h70, "R7 width word after write");
      apb_rd(8'h74, "R8 count word after write");

      // R10: unmapped and unaligned addresses
      apb_rd(8'h60, "R10 unmapped read");
      apb_rd(8'h01, "R10 unaligned read");
      apb_rd(8'h4C, "R10 gap read");
      apb_wr(8'h60, 32'hFFFF_FFFF);
      apb_wr(8'h02, 32'hFFFF_FFFF);
      apb_wr(8'h30, 32'hFFFF_FFFF);
      rd_all_regs("R10 unmapped write changes nothing");

      repeat (4) @(negedge pclk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule